// File: doc/BRIEF.md
# DDR2 Mode Register Load Sequencer

This controller-side block turns a request to program one of the four DDR2 mode registers into a single load-mode command on the memory command pins. The request carries the register selector and the individual field values. These are burst length, burst ordering, CAS latency, write recovery, DLL reset, power-down exit speed, DLL disable, reduced drive, additive latency, termination setting, OCD control and strobe disable. For the two upper extended registers the request carries a raw bit pattern. The block places each field at its bit position on the address bus, puts the register selector on the bank-address bus, and drives chip-select, RAS, CAS and WE low for one clock.

Before it issues a command, the block checks three things: every bank is precharged, the clock enable is high, and the base-register fields hold no reserved code. A request that fails any check produces a one-cycle error pulse and no command. After an accepted command the block reports busy and ignores new requests until the mode-register cycle time has elapsed. When the caller leaves the write-recovery field at zero, the block fills it from two timing parameters by rounding up.

Top module: `ddr2_mrs_seq`

## Requirements
- R1: After reset and on every cycle without a command, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), with ba and addr at zero. busy and err are low after reset.
- R2: An accepted request is sampled at a clock edge. It produces exactly one load-mode cycle (cs_n, ras_n, cas_n and we_n all 0) in the next cycle. In that cycle ba[1:0] carries the selector (00 base, 01 extended-1, 10 extended-2, 11 extended-3) and ba[2] is 0.
- R3: Base register layout. addr[2:0] is the burst code (length 4 gives 010, length 8 gives 011). addr[3] is the burst type (1 = interleaved). addr[6:4] holds the CAS latency value. addr[7] is always 0 and addr[8] is the DLL reset. addr[11:9] holds the write recovery in cycles minus one. addr[12] is the slow power-down exit and addr[13] is 0.
- R4: A base-register request is rejected in any of three cases: a burst length other than 4 or 8, a CAS latency below 3, or a write-recovery value other than 0 or 2..8.
- R5: A write-recovery request of 0 uses ceil(TWR_PS/TCK_PS), clamped to 2..8. With the defaults (15000 ps, 4000 ps) this gives 4 cycles, code 011.
- R6: Extended-1 layout. addr[0] is DLL disable and addr[1] is reduced drive. The termination setting splits across two bits: bit 0 goes to addr[2] and bit 1 goes to addr[6]. addr[5:3] holds the additive latency, addr[9:7] the OCD control, and addr[10] the strobe disable. addr[13:11] are 0.
- R7: For extended-2 and extended-3, ext_bits is copied to addr. The base-register field checks do not apply to these two registers.
- R8: A request made while banks_idle or cke_on is low is rejected.
- R9: A rejected request raises err for exactly the one cycle after it is sampled. It produces no command and leaves busy low.
- R10: busy is high for TMRD_CK-1 cycles, starting in the command cycle. A request held high gets its next command exactly TMRD_CK cycles after the previous one. Requests sampled while busy is high produce neither a command nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to load a mode register |
| req_sel | input | 2 | Register selector |
| banks_idle | input | 1 | All banks are precharged |
| cke_on | input | 1 | Clock enable is already high |
| bl_len | input | 4 | Burst length in beats (4 or 8) |
| burst_ilv | input | 1 | Interleaved burst ordering |
| cas_lat | input | 3 | CAS latency in cycles |
| wr_cyc | input | 4 | Write recovery in cycles, 0 = derive from parameters |
| dll_reset | input | 1 | DLL reset request |
| pd_slow | input | 1 | Slow power-down exit |
| dll_off | input | 1 | DLL disable |
| drv_half | input | 1 | Reduced output drive |
| add_lat | input | 3 | Additive latency |
| odt_sel | input | 2 | Termination setting |
| ocd_ctl | input | 3 | OCD control code |
| dqs_off | input | 1 | Strobe disable |
| ext_bits | input | ADDR_W | Raw pattern for extended-2/3 |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| busy | output | 1 | Cycle-time window running |
| err | output | 1 | Request rejected |

## Verification
The hardest case to reach from the ports is a request that arrives while the cycle-time window is still counting. A request sampled in that window must vanish without a trace, even when its fields are illegal and would otherwise raise an error. The bench reaches it by issuing a legal command, switching the fields to a reserved CAS latency while it keeps the request high through every busy cycle, and dropping the request in the first cycle that busy is low. A second sequence holds a legal request high without a break. This measures the exact spacing between two commands.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;

  typedef enum logic [1:0] {
    MSEL_BASE = 2'd0,
    MSEL_EXT1 = 2'd1,
    MSEL_EXT2 = 2'd2,
    MSEL_EXT3 = 2'd3
  } msel_e;

  typedef struct packed {
    logic [3:0] bl_len;
    logic       burst_ilv;
    logic [2:0] cas_lat;
    logic [3:0] wr_cyc;
    logic       dll_reset;
    logic       pd_slow;
    logic       dll_off;
    logic       drv_half;
    logic [2:0] add_lat;
    logic [1:0] odt_sel;
    logic [2:0] ocd_ctl;
    logic       dqs_off;
  } mode_fields_t;

  localparam int unsigned WR_MIN = 2;
  localparam int unsigned WR_MAX = 8;

  // ceil(twr/tck), then clamped into the encodable recovery range
  function automatic int unsigned wr_round(input int unsigned twr_ps,
                                           input int unsigned tck_ps);
    int unsigned q;
    q = (twr_ps + tck_ps - 1) / tck_ps;
    if (q < WR_MIN) q = WR_MIN;
    if (q > WR_MAX) q = WR_MAX;
    return q;
  endfunction

  function automatic logic bl_legal(input logic [3:0] len);
    return (len == 4'd4) || (len == 4'd8);
  endfunction

  function automatic logic [2:0] bl_code(input logic [3:0] len);
    return (len == 4'd8) ? 3'b011 : 3'b010;
  endfunction

  function automatic logic cl_legal(input logic [2:0] lat);
    return lat >= 3'd3;
  endfunction

  function automatic logic wr_req_legal(input logic [3:0] cyc);
    return (cyc == 4'd0) || ((cyc >= 4'd2) && (cyc <= 4'd8));
  endfunction

endpackage

// File: rtl/mrs_field_pack.sv
module mrs_field_pack
  import ddr2_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned TWR_PS = 15000,
  parameter int unsigned TCK_PS = 4000
) (
  input  logic [1:0]        sel,
  input  mode_fields_t      fld,
  input  logic [ADDR_W-1:0] ext_bits,
  output logic [ADDR_W-1:0] addr_word,
  output logic              fields_ok
);
  localparam int unsigned WR_CYC_D  = wr_round(TWR_PS, TCK_PS);
  localparam logic [2:0]  WR_CODE_D = 3'(WR_CYC_D - 1);

  logic [2:0] wr_code;

  always_comb begin
    if (fld.wr_cyc == 4'd0) wr_code = WR_CODE_D;
    else                    wr_code = 3'(fld.wr_cyc - 4'd1);
  end

  always_comb begin
    addr_word = '0;
    fields_ok = 1'b1;
    unique case (msel_e'(sel))
      MSEL_BASE: begin
        fields_ok       = bl_legal(fld.bl_len) && cl_legal(fld.cas_lat) &&
                          wr_req_legal(fld.wr_cyc);
        addr_word[2:0]  = bl_code(fld.bl_len);
        addr_word[3]    = fld.burst_ilv;
        addr_word[6:4]  = fld.cas_lat;
        addr_word[7]    = 1'b0;
        addr_word[8]    = fld.dll_reset;
        addr_word[11:9] = wr_code;
        addr_word[12]   = fld.pd_slow;
      end
      MSEL_EXT1: begin
        addr_word[0]   = fld.dll_off;
        addr_word[1]   = fld.drv_half;
        addr_word[2]   = fld.odt_sel[0];
        addr_word[5:3] = fld.add_lat;
        addr_word[6]   = fld.odt_sel[1];
        addr_word[9:7] = fld.ocd_ctl;
        addr_word[10]  = fld.dqs_off;
      end
      default: begin
        addr_word = ext_bits;
      end
    endcase
  end

  always_comb begin
    if (fields_ok && (msel_e'(sel) == MSEL_BASE))
      a_wr_code_r5: assert (addr_word[11:9] != 3'b000);
  end

endmodule

// File: rtl/mrs_tmrd_timer.sv
module mrs_tmrd_timer #(
  parameter int unsigned TMRD_CK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned CNT_W = (TMRD_CK < 2) ? 1 : $clog2(TMRD_CK + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TMRD_CK - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= LOAD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R10: the admission logic never loads while a window is still open
  p_load_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));

endmodule

// File: rtl/mrs_cmd_out.sv
module mrs_cmd_out #(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned BA_W    = 3,
  parameter int unsigned TMRD_CK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              refuse,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr_word,
  input  logic              busy,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              err
);
  localparam int unsigned GAP_W = $clog2(TMRD_CK + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(TMRD_CK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
      err   <= 1'b0;
    end else begin
      err   <= refuse;
      cs_n  <= 1'b0;
      ras_n <= ~fire;
      cas_n <= ~fire;
      we_n  <= ~fire;
      ba    <= fire ? BA_W'(sel) : '0;
      addr  <= fire ? addr_word : '0;
    end
  end

  logic is_load;
  assign is_load = !cs_n && !ras_n && !cas_n && !we_n;

  // checker counter: cycles since the previous load command
  logic [GAP_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= GAP_MIN;
    else if (is_load)           since_q <= GAP_W'(1);
    else if (since_q < GAP_MIN) since_q <= since_q + 1'b1;
  end

  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (since_q >= GAP_MIN));

  p_ba_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |-> (ba[BA_W-1:2] == '0));

  generate
    if (TMRD_CK > 1) begin : g_busy_chk
      p_busy_in_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |-> busy);
    end
  endgenerate

endmodule

// File: rtl/ddr2_mrs_seq.sv
module ddr2_mrs_seq
  import ddr2_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned BA_W    = 3,
  parameter int unsigned TMRD_CK = 4,
  parameter int unsigned TWR_PS  = 15000,
  parameter int unsigned TCK_PS  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_sel,
  input  logic              banks_idle,
  input  logic              cke_on,
  input  logic [3:0]        bl_len,
  input  logic              burst_ilv,
  input  logic [2:0]        cas_lat,
  input  logic [3:0]        wr_cyc,
  input  logic              dll_reset,
  input  logic              pd_slow,
  input  logic              dll_off,
  input  logic              drv_half,
  input  logic [2:0]        add_lat,
  input  logic [1:0]        odt_sel,
  input  logic [2:0]        ocd_ctl,
  input  logic              dqs_off,
  input  logic [ADDR_W-1:0] ext_bits,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              err
  ,output logic             busy
);
  mode_fields_t      fld;
  logic [ADDR_W-1:0] addr_word;
  logic              fields_ok;
  logic              take_evt;
  logic              dram_ready;
  logic              accept_evt;
  logic              reject_evt;

  assign fld = '{bl_len: bl_len, burst_ilv: burst_ilv, cas_lat: cas_lat,
                 wr_cyc: wr_cyc, dll_reset: dll_reset, pd_slow: pd_slow,
                 dll_off: dll_off, drv_half: drv_half, add_lat: add_lat,
                 odt_sel: odt_sel, ocd_ctl: ocd_ctl, dqs_off: dqs_off};

  mrs_field_pack #(.ADDR_W(ADDR_W), .TWR_PS(TWR_PS), .TCK_PS(TCK_PS)) u_pack (
    .sel(req_sel), .fld(fld), .ext_bits(ext_bits),
    .addr_word(addr_word), .fields_ok(fields_ok)
  );

  // admission: a request counts only when no window is open
  assign take_evt   = req_valid && !busy;
  assign dram_ready = banks_idle && cke_on;
  assign accept_evt = take_evt && dram_ready && fields_ok;
  assign reject_evt = take_evt && !(dram_ready && fields_ok);

  mrs_tmrd_timer #(.TMRD_CK(TMRD_CK)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .busy(busy)
  );

  mrs_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD_CK(TMRD_CK)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(accept_evt), .refuse(reject_evt),
    .sel(req_sel), .addr_word(addr_word), .busy(busy),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .err(err)
  );

  logic load_seen;
  assign load_seen = !cs_n && !ras_n && !cas_n && !we_n;

  p_cmd_when_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |-> $past(banks_idle && cke_on));

  p_err_is_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cs_n && ras_n && cas_n && we_n && !busy));

  p_err_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid));

  p_base_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_seen && ba[1:0] == 2'b00) |->
      ((addr[2:0] == 3'b010 || addr[2:0] == 3'b011) && addr[6:4] >= 3'd3 &&
       addr[11:9] != 3'b000 && !addr[7]));

endmodule

// File: tb/ddr2_mrs_seq_tb.sv
`timescale 1ns/1ps
module ddr2_mrs_seq_tb_top;
  localparam int unsigned TMRD = 4;
  localparam int unsigned NV   = 16;

  typedef struct packed {
    logic [1:0]  sel;
    logic [3:0]  bl;
    logic        bt;
    logic [2:0]  cl;
    logic [3:0]  wr;
    logic        dllr;
    logic        pds;
    logic        dlld;
    logic        drv;
    logic [2:0]  al;
    logic [1:0]  odt;
    logic [2:0]  ocd;
    logic        dqs;
    logic [13:0] ext;
    logic        pre;
    logic        cke;
    logic        e_err;
    logic [13:0] e_addr;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R3 R5: len4, seq, CL3, derived WR=4 (code 011), DLL reset
    '{2'd0,4'd4,1'b0,3'd3,4'd0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b0,14'h0732},
    // R3: len8, interleave, CL7, WR8, slow exit
    '{2'd0,4'd8,1'b1,3'd7,4'd8,1'b0,1'b1,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b0,14'h1E7B},
    // R3: len4, interleave, CL5, WR2
    '{2'd0,4'd4,1'b1,3'd5,4'd2,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b0,14'h025A},
    // R4: CL2 reserved
    '{2'd0,4'd4,1'b0,3'd2,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b1,14'h0000},
    // R4: burst length 2
    '{2'd0,4'd2,1'b0,3'd3,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b1,14'h0000},
    // R4: WR 9
    '{2'd0,4'd4,1'b0,3'd3,4'd9,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b1,14'h0000},
    // R4: WR 1
    '{2'd0,4'd8,1'b0,3'd4,4'd1,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b1,14'h0000},
    // R6: DLL off, odt=01, AL3, OCD 111, strobe off
    '{2'd1,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b1,1'b0,3'd3,2'b01,3'b111,1'b1,14'h0000,1'b1,1'b1,1'b0,14'h079D},
    // R6: half drive, AL5, odt=10
    '{2'd1,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b0,1'b1,3'd5,2'b10,3'b000,1'b0,14'h0000,1'b1,1'b1,1'b0,14'h006A},
    // R7: extended-2
    '{2'd2,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0080,1'b1,1'b1,1'b0,14'h0080},
    // R7: extended-3
    '{2'd3,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h1234,1'b1,1'b1,1'b0,14'h1234},
    // R8: bank open
    '{2'd0,4'd4,1'b0,3'd3,4'd0,1'b1,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b0,1'b1,1'b1,14'h0000},
    // R8: clock enable low
    '{2'd1,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b1,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b0,1'b1,14'h0000},
    // R7: base-field checks ignored for extended-2
    '{2'd2,4'd0,1'b0,3'd0,4'd15,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h2A05,1'b1,1'b1,1'b0,14'h2A05},
    // R8: extended-3 with bank open
    '{2'd3,4'd0,1'b0,3'd0,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0011,1'b0,1'b1,1'b1,14'h0000},
    // R3: len8, seq, CL4, derived WR
    '{2'd0,4'd8,1'b0,3'd4,4'd0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd0,3'd0,1'b0,14'h0000,1'b1,1'b1,1'b0,14'h0643}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_sel = '0;
  logic banks_idle = 1'b0, cke_on = 1'b0;
  logic [3:0] bl_len = '0;
  logic burst_ilv = 1'b0;
  logic [2:0] cas_lat = '0;
  logic [3:0] wr_cyc = '0;
  logic dll_reset = 1'b0, pd_slow = 1'b0, dll_off = 1'b0, drv_half = 1'b0;
  logic [2:0] add_lat = '0;
  logic [1:0] odt_sel = '0;
  logic [2:0] ocd_ctl = '0;
  logic dqs_off = 1'b0;
  logic [13:0] ext_bits = '0;
  logic cs_n, ras_n, cas_n, we_n, busy, err;
  logic [2:0] ba;
  logic [13:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddr2_mrs_seq #(.TMRD_CK(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .banks_idle(banks_idle), .cke_on(cke_on), .bl_len(bl_len),
    .burst_ilv(burst_ilv), .cas_lat(cas_lat), .wr_cyc(wr_cyc),
    .dll_reset(dll_reset), .pd_slow(pd_slow), .dll_off(dll_off),
    .drv_half(drv_half), .add_lat(add_lat), .odt_sel(odt_sel),
    .ocd_ctl(ocd_ctl), .dqs_off(dqs_off), .ext_bits(ext_bits),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .err(err), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic apply(input vec_t v);
    req_sel = v.sel; bl_len = v.bl; burst_ilv = v.bt; cas_lat = v.cl;
    wr_cyc = v.wr; dll_reset = v.dllr; pd_slow = v.pds; dll_off = v.dlld;
    drv_half = v.drv; add_lat = v.al; odt_sel = v.odt; ocd_ctl = v.ocd;
    dqs_off = v.dqs; ext_bits = v.ext; banks_idle = v.pre; cke_on = v.cke;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pins", 32'(pins()), 32'h7);
    check("R1 reset ba/addr", {15'd0, ba, addr}, 32'd0);
    check("R1 reset busy/err", {30'd0, busy, err}, 32'd0);

    for (int i = 0; i < int'(NV); i++) begin
      string tg;
      apply(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (VECS[i].e_err) begin
        check($sformatf("R9 v%0d err", i), 32'(err), 32'd1);
        check($sformatf("R9 v%0d pins nop", i), 32'(pins()), 32'h7);
        check($sformatf("R9 v%0d busy", i), 32'(busy), 32'd0);
      end else begin
        case (VECS[i].sel)
          2'd0:    tg = "R3";
          2'd1:    tg = "R6";
          default: tg = "R7";
        endcase
        check($sformatf("R2 v%0d pins load", i), 32'(pins()), 32'h0);
        check($sformatf("R2 v%0d ba", i), 32'(ba), {30'd0, VECS[i].sel});
        check($sformatf("%s v%0d addr", tg, i), 32'(addr), 32'(VECS[i].e_addr));
        check($sformatf("R10 v%0d busy", i), 32'(busy), 32'd1);
        check($sformatf("R9 v%0d no err", i), 32'(err), 32'd0);
      end
      @(negedge clk);
      check($sformatf("R1 v%0d nop after", i), 32'(pins()), 32'h7);
      check($sformatf("R9 v%0d err single", i), 32'(err), 32'd0);
      repeat (TMRD) @(negedge clk);
    end

    // R10: requests while busy are ignored, even illegal ones
    apply(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R10 first load", 32'(pins()), 32'h0);
    cas_lat = 3'd0;
    for (int k = 0; k < int'(TMRD) - 2; k++) begin
      @(negedge clk);
      check("R10 busy window", {29'd0, busy, err, pins() == 4'h7}, 32'b101);
    end
    @(negedge clk);
    check("R10 busy drops", {29'd0, busy, err, pins() == 4'h7}, 32'b001);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 held req ignored", {30'd0, err, pins() == 4'h7}, 32'b01);
    repeat (TMRD) @(negedge clk);

    // R10: command spacing with a request held high
    apply(VECS[1]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R10 spacing first", 32'(pins()), 32'h0);
    begin
      int gap = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        gap++;
        if (pins() == 4'h0) break;
      end
      req_valid = 1'b0;
      check("R10 spacing", 32'(gap), 32'(TMRD));
    end
    repeat (TMRD + 1) @(negedge clk);
    check("R1 idle at end", {28'd0, pins()}, 32'h7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule